// File: doc/BRIEF.md
# Spread-Spectrum Divide-Ratio Modulator

This block produces the divide ratio for a fractional-N output divider whose output frequency must be swept by a triangle wave. A nominal ratio (8-bit integer, 16-bit fraction) is offset by a ramp. The ramp changes by a programmable step on every divider output cycle. After a programmable number of cycles it turns round, so one full triangle lasts twice that count. The block is clocked by the divider output itself, so the half-period is counted in output cycles.

Two spread shapes are available. Down spread only ever raises the ratio, which only ever lowers the frequency. Centre spread swings the ratio equally above and below nominal. A first-order fractional accumulator turns the modulated ratio into a per-cycle integer divide choice of N or N+1.

The block has no data stream with flow control. A new ratio and divide choice are valid on every clock, and the divider consumes them unconditionally, so there is no back-pressure path and no valid/ready pair. All pins are plain control or data levels.

Top module: `ssm_divmod`

## Requirements
- R1: After reset the ramp is zero and the accumulator is zero. With `en` low, `ratio_int`/`ratio_frac` equal `nom_int`/`nom_frac` and `div_n` equals `nom_int`.
- R2: While `en` is low, `ratio_int`/`ratio_frac` equal `nom_int`/`nom_frac` in the same cycle. `half_per`, `step` and `spread_down` have no effect on them.
- R3: With `spread_down` = 1 (down spread), the ratio equals the latched nominal plus the ramp and is never below the latched nominal. `step` has an LSB of 2^-20 of one divide unit, which is 4 guard bits below the 2^-16 LSB of `ratio_frac`. The ratio is the sum truncated toward minus infinity to 2^-16.
- R4: The ramp rises by `step` on each of `half_per` enabled clocks and then falls by `step` on each of the next `half_per` clocks, returning exactly to zero.
- R5: With `spread_down` = 0 (centre spread), the ratio equals nominal plus the ramp minus floor(step*half_per/2) in 2^-20 units, truncated to 2^-16.
- R6: The nominal, step, half-period and spread-mode values are captured in three cases only: on each clock with `en` low, at the clock that ends a falling half (ramp back to zero), and on each clock while the captured half-period is zero. Changes at any other time have no effect until the next capture.
- R7: `en` low for one clock clears the ramp. The next enabled clock restarts a rising half from zero.
- R8: A captured half-period of zero holds the ramp at zero, so the ratio equals the captured nominal.
- R9: Each clock, `div_n` = `ratio_int` + carry out of (accumulator + `ratio_frac`), modulo 2^16. The accumulator then takes the 16-bit sum.
- R10: Steps smaller than one LSB of `ratio_frac` accumulate without loss in the guard bits, so the ratio fraction advances once every 16 steps of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider output clock; one modulation update per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulation enable |
| spread_down | input | 1 | 1 = down spread, 0 = centre spread |
| nom_int | input | 8 | Nominal ratio, integer part |
| nom_frac | input | 16 | Nominal ratio, fraction part |
| half_per | input | 12 | Half-period of the triangle in output cycles |
| step | input | 16 | Ramp increment per cycle, LSB 2^-20 |
| ratio_int | output | 8 | Modulated ratio, integer part |
| ratio_frac | output | 16 | Modulated ratio, fraction part |
| div_n | output | 9 | Integer divide to use this cycle (N or N+1) |

## Verification
The bench targets the turning points of the triangle. An off-by-one in the half-period counter would stretch or shorten one side, so the ramp would drift away from zero cycle by cycle. Step and period are changed mid-sweep and the nominal is changed while enabled. A design that took them at once would break the symmetry, and the ramp would no longer come back to zero. Centre spread is run with an odd step times period, which tests the floor of the half-span. Sub-LSB steps test that guard bits are kept rather than truncated. A half-period of zero and a one-clock enable drop test that the ramp is flattened and restarted from zero rather than resumed. The divide choice is compared on every cycle, so a lost or doubled carry shows up as a wrong N or N+1.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {
    SPREAD_CENTRE = 1'b0,
    SPREAD_DOWN   = 1'b1
  } spread_e;
endpackage

// File: rtl/ssm_ramp.sv
// Triangle ramp generator with parameter capture at the trough.
module ssm_ramp
  import ssm_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int STEP_W = 16,
  parameter int IF_W   = 24,
  parameter int RAMP_W = PER_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  spread_e           mode_i,
  input  logic [IF_W-1:0]   nom_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic [PER_W-1:0]  per_q,
  output logic [STEP_W-1:0] step_q,
  output spread_e           mode_q,
  output logic [IF_W-1:0]   nom_q
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_last;
  logic             fall_q;
  logic             idle;
  logic             at_turn;
  logic             reload;

  assign idle     = !en || (per_q == '0);
  assign per_last = per_q - 1'b1;
  assign at_turn  = (cnt_q == per_last);
  assign reload   = idle || (at_turn && fall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fall_q <= 1'b0;
      ramp_o <= '0;
      per_q  <= '0;
      step_q <= '0;
      mode_q <= SPREAD_CENTRE;
      nom_q  <= '0;
    end else begin
      if (reload) begin
        per_q  <= per_i;
        step_q <= step_i;
        mode_q <= mode_i;
        nom_q  <= nom_i;
      end
      if (idle) begin
        cnt_q  <= '0;
        fall_q <= 1'b0;
        ramp_o <= '0;
      end else begin
        ramp_o <= fall_q ? ramp_o - RAMP_W'(step_q) : ramp_o + RAMP_W'(step_q);
        if (at_turn) begin
          cnt_q  <= '0;
          fall_q <= ~fall_q;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_RAMP_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ramp_o == '0)); // R7
  AST_RAMP_BACK_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_q != '0 && at_turn && fall_q) |=> (ramp_o == '0)); // R4
  AST_PARAMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_q != '0 && !(at_turn && fall_q)) |=>
      ($stable(step_q) && $stable(per_q) && $stable(nom_q) && $stable(mode_q))); // R6
endmodule

// File: rtl/ssm_mix.sv
// Combines captured nominal, ramp and centre offset into the modulated ratio.
module ssm_mix
  import ssm_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 4,
  parameter int PER_W   = 12,
  parameter int STEP_W  = 16
) (
  input  logic                      en,
  input  logic [INT_W+FRAC_W-1:0]   nom_in,
  input  logic [INT_W+FRAC_W-1:0]   nom_q,
  input  logic [PER_W+STEP_W-1:0]   ramp,
  input  logic [PER_W-1:0]          per_q,
  input  logic [STEP_W-1:0]         step_q,
  input  spread_e                   mode_q,
  output logic [INT_W+FRAC_W-1:0]   ratio
);
  localparam int IF_W   = INT_W + FRAC_W;
  localparam int RAMP_W = PER_W + STEP_W;
  localparam int NOM_W  = IF_W + GUARD_W;
  localparam int TOT_W  = ((RAMP_W > NOM_W) ? RAMP_W : NOM_W) + 2;

  logic [RAMP_W-1:0] span;
  logic [RAMP_W-1:0] half;
  logic [TOT_W-1:0]  nom_g;
  logic [TOT_W-1:0]  tot;
  logic              unused_mix;

  assign span  = RAMP_W'(step_q) * RAMP_W'(per_q);
  assign half  = (mode_q == SPREAD_CENTRE) ? (span >> 1) : '0;
  assign nom_g = TOT_W'({nom_q, {GUARD_W{1'b0}}});
  assign tot   = nom_g + TOT_W'(ramp) - TOT_W'(half);
  assign ratio = en ? tot[GUARD_W +: IF_W] : nom_in;

  assign unused_mix = ^{tot[TOT_W-1 -: (TOT_W-GUARD_W-IF_W)], tot[GUARD_W-1:0]};
endmodule

// File: rtl/ssm_sigma.sv
// First-order fractional accumulator choosing N or N+1 each cycle.
module ssm_sigma #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic [INT_W:0]    div_n
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, ratio_frac};
  assign div_n = {1'b0, ratio_int} + {{INT_W{1'b0}}, sum[FRAC_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[FRAC_W-1:0];
  end

  AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n != {1'b0, ratio_int}) |=> (acc_q < $past(acc_q))); // R9
  AST_NO_CARRY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n == {1'b0, ratio_int}) |=> (acc_q >= $past(acc_q))); // R9
endmodule

// File: rtl/ssm_divmod.sv
// Spread-spectrum divide-ratio modulator, top level.
module ssm_divmod
  import ssm_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 4,
  parameter int PER_W   = 12,
  parameter int STEP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              spread_down,
  input  logic [INT_W-1:0]  nom_int,
  input  logic [FRAC_W-1:0] nom_frac,
  input  logic [PER_W-1:0]  half_per,
  input  logic [STEP_W-1:0] step,
  output logic [INT_W-1:0]  ratio_int,
  output logic [FRAC_W-1:0] ratio_frac,
  output logic [INT_W:0]    div_n
);
  localparam int IF_W   = INT_W + FRAC_W;
  localparam int RAMP_W = PER_W + STEP_W;

  logic [RAMP_W-1:0] ramp;
  logic [PER_W-1:0]  per_q;
  logic [STEP_W-1:0] step_q;
  spread_e           mode_q;
  logic [IF_W-1:0]   nom_q;
  logic [IF_W-1:0]   ratio;

  ssm_ramp #(
    .PER_W (PER_W),
    .STEP_W(STEP_W),
    .IF_W  (IF_W),
    .RAMP_W(RAMP_W)
  ) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .mode_i(spread_e'(spread_down)),
    .nom_i ({nom_int, nom_frac}),
    .per_i (half_per),
    .step_i(step),
    .ramp_o(ramp),
    .per_q (per_q),
    .step_q(step_q),
    .mode_q(mode_q),
    .nom_q (nom_q)
  );

  ssm_mix #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .GUARD_W(GUARD_W),
    .PER_W  (PER_W),
    .STEP_W (STEP_W)
  ) u_mix (
    .en    (en),
    .nom_in({nom_int, nom_frac}),
    .nom_q (nom_q),
    .ramp  (ramp),
    .per_q (per_q),
    .step_q(step_q),
    .mode_q(mode_q),
    .ratio (ratio)
  );

  assign ratio_int  = ratio[IF_W-1 -: INT_W];
  assign ratio_frac = ratio[FRAC_W-1:0];

  ssm_sigma #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) u_sigma (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_int (ratio_int),
    .ratio_frac(ratio_frac),
    .div_n     (div_n)
  );

  AST_OFF_IS_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> ({ratio_int, ratio_frac} == {nom_int, nom_frac})); // R2
  AST_DOWN_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_q == SPREAD_DOWN) |-> (ratio >= nom_q)); // R3
  AST_FLAT_PERIOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_q == '0) |-> (ratio == nom_q)); // R8
endmodule

// File: tb/ssm_divmod_test.sv
`timescale 1ns/1ps
module ssm_divmod_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        spread_down = 1'b0;
  logic [7:0]  nom_int = 8'd40;
  logic [15:0] nom_frac = 16'h4000;
  logic [11:0] half_per = 12'd5;
  logic [15:0] step = 16'h1234;
  logic [7:0]  ratio_int;
  logic [15:0] ratio_frac;
  logic [8:0]  div_n;

  always #4 clk = ~clk;

  ssm_divmod uut (
    .clk(clk), .rst_n(rst_n), .en(en), .spread_down(spread_down),
    .nom_int(nom_int), .nom_frac(nom_frac), .half_per(half_per), .step(step),
    .ratio_int(ratio_int), .ratio_frac(ratio_frac), .div_n(div_n)
  );

  typedef struct {
    logic [23:0] ratio;
    logic [8:0]  divn;
  } exp_t;

  exp_t   sb[$];
  int     vectors = 0;
  int     fails = 0;
  bit     done = 1'b0;
  string  phase = "R1";

  // reference state, built from the requirements
  longint n_m = 0;
  longint sp_m = 0, ss_m = 0;
  bit     down_m = 1'b0;
  longint nom_m = 0;
  longint acc_m = 0;
  longint prev_frac = 0;

  task automatic capture();
    sp_m   = half_per;
    ss_m   = step;
    down_m = spread_down;
    nom_m  = {nom_int, nom_frac};
  endtask

  // predictor: advances at each edge, then forms the expected outputs
  always @(posedge clk) begin
    exp_t   e;
    longint r, tot;
    if (!rst_n) begin
      n_m = 0; sp_m = 0; ss_m = 0; down_m = 1'b0; nom_m = 0; acc_m = 0;
    end else begin
      acc_m = (acc_m + prev_frac) & 64'hFFFF;            // R9
      if (!en || sp_m == 0) begin
        n_m = 0;
        capture();                                     // R6 / R8
      end else begin
        n_m = n_m + 1;
        if (n_m == 2 * sp_m) begin
          n_m = 0;
          capture();                                   // R4 / R6
        end
      end
    end
    #2;
    if (!en) begin
      e.ratio = {nom_int, nom_frac};                   // R2
    end else begin
      r   = (n_m <= sp_m) ? n_m * ss_m : (2 * sp_m - n_m) * ss_m;
      tot = (nom_m << 4) + r - (down_m ? 0 : ((ss_m * sp_m) >> 1));  // R3 / R5
      e.ratio = 24'((tot >>> 4) & 64'hFFFFFF);
    end
    e.divn = 9'(e.ratio[23:16]) + 9'((acc_m + e.ratio[15:0]) >> 16);
    prev_frac = e.ratio[15:0];
    if (rst_n) sb.push_back(e);
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && sb.size() > 0 && !done) begin
      e = sb.pop_front();
      vectors++;
      if ({ratio_int, ratio_frac} !== e.ratio) begin
        fails++;
        $display("FAIL %s ratio got %h expected %h", phase, {ratio_int, ratio_frac}, e.ratio);
      end
      vectors++;
      if (div_n !== e.divn) begin
        fails++;
        $display("FAIL R9 (%s) div_n got %0d expected %0d", phase, div_n, e.divn);
      end
    end
  end

  task automatic run(input int cycles, input string ph);
    phase = ph;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;                                          // R1 reset state
    if ({ratio_int, ratio_frac, div_n} !== {8'd40, 16'h4000, 9'd40}) begin
      fails++;
      $display("FAIL R1 reset got %h/%h/%0d expected 28/4000/40", ratio_int, ratio_frac, div_n);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    run(2, "R1");
    // R2: enable low, other controls wiggle
    spread_down = 1'b1; half_per = 12'd3; step = 16'hFFFF; run(2, "R2");
    spread_down = 1'b0; half_per = 12'd0; step = 16'h0001; nom_frac = 16'hC000; run(2, "R2");
    // R3: down spread
    spread_down = 1'b1; half_per = 12'd6; step = 16'h0A37; nom_frac = 16'h4000; run(1, "R3");
    en = 1'b1; run(30, "R3");
    // R4: change step while sweeping; takes effect only at the trough
    step = 16'h2222; half_per = 12'd4; run(3, "R4");
    nom_int = 8'd41; run(30, "R4");
    // R7 + R5: drop enable, switch to centre spread with odd span
    en = 1'b0; spread_down = 1'b0; half_per = 12'd7; step = 16'h3001; run(2, "R7");
    en = 1'b1; run(40, "R5");
    // R6: mid-sweep changes of every captured value
    run(3, "R6");
    step = 16'h0500; half_per = 12'd9; nom_int = 8'd60; spread_down = 1'b1; run(45, "R6");
    // R7: one-clock enable drop mid-sweep, restart from zero
    run(4, "R7");
    en = 1'b0; run(1, "R7");
    en = 1'b1; run(20, "R7");
    // R8: zero half-period
    en = 1'b0; half_per = 12'd0; step = 16'hFFFF; run(1, "R8");
    en = 1'b1; run(10, "R8");
    // R10: sub-LSB step
    en = 1'b0; half_per = 12'd40; step = 16'h0001; nom_frac = 16'hFFF0; run(1, "R10");
    en = 1'b1; run(90, "R10");
    // R5: extreme centre span
    en = 1'b0; half_per = 12'hFFF; step = 16'hFFFF; spread_down = 1'b0; nom_int = 8'd200;
    nom_frac = 16'h8001; run(1, "R5");
    en = 1'b1; run(40, "R5");
    en = 1'b0; run(3, "R2");
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      finish_up();
    end
  end
endmodule